// File: doc/BRIEF.md
# Periodic Down-Counter with Compare Interrupt

This block is a memory-mapped timer whose counter runs downward by one on every cycle in which a single-cycle tick-enable input is high. When the count passes through zero, it either reloads from a programmable load register or rolls over to all-ones. The choice comes from a control bit. A compare register is matched against the running count. Each match, while the timer is running and compare events are enabled, sets a sticky status flag. The interrupt output is that flag gated by the compare-enable bit.

Software reaches five 32-bit words through a simple single-cycle register port. The word index is `bus_word`, writes happen when `bus_sel` and `bus_wr` are both high, and the read data follows `bus_word` combinationally. Control writes can do three extra things: perform a soft reset, restart the count when the timer is switched on, and arm an immediate counter overwrite that takes effect on later load-register writes. The four low-power control bits are stored and read back but have no other effect.

The counter width is the parameter `CNT_W` (default 32). The load, compare and count words are zero-extended to 32 bits on read.

Top module: `cmp_downtimer`

## Requirements
- R1: After hard reset the words read: control (word 0) = 0, status (word 1) = 0, load (word 2) = all-ones, compare (word 3) = 0, count (word 4) = all-ones; `irq` is 0.
- R2: A control write without bit 16 set stores bits [25:0] of the written data; bits [31:26] of the control word always read 0.
- R3: A control write with bit 16 (soft reset) set stores only bit 0 (run), bit 1 (restart-on-enable) and bits 18..21 (low-power stop/doze/wait/debug) of the written data; all other control bits, bit 16 included, read 0 afterwards.
- R4: A soft reset also clears the status flag, sets load to all-ones, clears compare and sets the count to all-ones; if run is still set, counting continues downward from there.
- R5: A control write that takes run (bit 0) from 0 to 1 with restart-on-enable (bit 1) set loads the count from the load register when reload (bit 3) is set, or with all-ones when it is clear.
- R6: A control write that takes run from 0 to 1 with bit 1 clear leaves the count at its current value, and counting resumes from it.
- R7: While run is set, each cycle with `tick` high lowers the count by one; a tick at count zero loads the load value when reload (bit 3) is set, otherwise all-ones.
- R8: While run is clear, the count holds and no compare event occurs, whatever `tick` does.
- R9: A compare event happens on a cycle with `tick` high, run set, compare-enable (bit 2) set and count equal to the compare value (zero included); it sets the status flag (word 1 bit 0), and every pass through the value gives a new event.
- R10: Writing word 1 with bit 0 = 1 clears the status flag, and writing bit 0 = 0 leaves it unchanged; a compare event in the same cycle wins over the clear.
- R11: A write to the load word while overwrite (control bit 17) is set also replaces the count with the written value; with bit 17 clear the count is not touched.
- R12: `irq` is high exactly when the status flag and compare-enable (bit 2) are both set.
- R13: The count word is read-only; writes to word 4 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| tick | input | 1 | Count-enable strobe, one step per high cycle |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_word | input | 3 | Word index: 0 control, 1 status, 2 load, 3 compare, 4 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word`, combinational |
| irq | output | 1 | Compare interrupt |

## Verification
The bench builds the timer with `CNT_W` = 12. With that width the roll-over to all-ones, a soft-reset restart from all-ones and a pass through zero all fit within a few thousand ticks, so the wrap path of R7 and the continued run of R4 are reached in directed cases. Small load and compare values drawn at random make compare hits, zero-valued compares and clear/set collisions at the status flag occur often. The bench checks these against its own cycle model of the register rules.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned WORD_W     = 3;
  localparam int unsigned CTL_STORED = 26;

  // control bit positions
  localparam int unsigned B_RUN     = 0;
  localparam int unsigned B_RESTART = 1;
  localparam int unsigned B_CMPIE   = 2;
  localparam int unsigned B_RELOAD  = 3;
  localparam int unsigned B_SWRST   = 16;
  localparam int unsigned B_OVW     = 17;
  localparam int unsigned B_LP_STOP = 18;
  localparam int unsigned B_LP_DOZE = 19;
  localparam int unsigned B_LP_WAIT = 20;
  localparam int unsigned B_LP_DBG  = 21;

  localparam logic [DATA_W-1:0] STORE_MASK = (32'h1 << CTL_STORED) - 32'h1;
  localparam logic [DATA_W-1:0] KEEP_MASK  =
      (32'h1 << B_RUN) | (32'h1 << B_RESTART) |
      (32'h1 << B_LP_STOP) | (32'h1 << B_LP_DOZE) |
      (32'h1 << B_LP_WAIT) | (32'h1 << B_LP_DBG);

  typedef enum logic [WORD_W-1:0] {
    W_CTRL  = 3'd0,
    W_STAT  = 3'd1,
    W_LOAD  = 3'd2,
    W_CMP   = 3'd3,
    W_COUNT = 3'd4
  } word_e;

  typedef struct packed {
    logic run;
    logic restart;
    logic cmp_ie;
    logic reload;
    logic ovw;
  } ctl_t;

  // value the control word takes after a write of w
  function automatic logic [DATA_W-1:0] ctl_written(input logic [DATA_W-1:0] w);
    if (w[B_SWRST]) return w & STORE_MASK & KEEP_MASK;
    return w & STORE_MASK;
  endfunction

  function automatic ctl_t ctl_fields(input logic [DATA_W-1:0] c);
    ctl_t f;
    f.run     = c[B_RUN];
    f.restart = c[B_RESTART];
    f.cmp_ie  = c[B_CMPIE];
    f.reload  = c[B_RELOAD];
    f.ovw     = c[B_OVW];
    return f;
  endfunction

endpackage

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             reload_mode,
  input  logic [CNT_W-1:0] load_val,
  input  logic             force_vld,
  input  logic [CNT_W-1:0] force_val,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic             rl,
                                            input logic [CNT_W-1:0] lv);
    if (cur == '0) return rl ? lv : ALL_ONES;
    return cur - 1'b1;
  endfunction

  logic advance;
  logic at_zero;
  assign advance = run & tick;
  assign at_zero = advance & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= ALL_ONES;
    else if (force_vld) cnt <= force_val;
    else if (advance)   cnt <= step(cnt, reload_mode, load_val);
  end

  // R7: ordinary step lowers the count by one
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_vld && advance && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R7: tick at zero reloads or wraps
  a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_vld && at_zero) |=>
      (cnt == ($past(reload_mode) ? $past(load_val) : ALL_ONES)));

  // R8: without a running tick and without a forced load the count holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_vld && !advance) |=> $stable(cnt));

endmodule

// File: rtl/cdt_compare.sv
module cdt_compare #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             run,
  input  logic             cmp_ie,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             cmp_evt
);

  function automatic logic match(input logic [CNT_W-1:0] a,
                                 input logic [CNT_W-1:0] b);
    return a == b;
  endfunction

  logic armed;
  assign armed   = run & cmp_ie & tick;
  assign cmp_evt = armed & match(cnt, cmp_val);

endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cmp_evt,
  output ctl_t              ctl,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              status,
  output logic              force_vld,
  output logic [CNT_W-1:0]  force_val
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [DATA_W-1:0] ctl_q;
  logic [CNT_W-1:0]  load_q;
  logic [CNT_W-1:0]  cmp_q;
  logic              stat_q;

  logic wr_en, wr_ctl, wr_stat, wr_load, wr_cmp;
  logic swr_now, run_rise, ovw_now, stat_clr;

  assign wr_en   = bus_sel & bus_wr;
  assign wr_ctl  = wr_en & (bus_word == W_CTRL);
  assign wr_stat = wr_en & (bus_word == W_STAT);
  assign wr_load = wr_en & (bus_word == W_LOAD);
  assign wr_cmp  = wr_en & (bus_word == W_CMP);

  assign swr_now  = wr_ctl & bus_wdata[B_SWRST];
  assign run_rise = wr_ctl & ~swr_now & bus_wdata[B_RUN] & ~ctl_q[B_RUN]
                  & bus_wdata[B_RESTART];
  assign ovw_now  = wr_load & ctl_q[B_OVW];
  assign stat_clr = wr_stat & bus_wdata[0];

  // counter overwrite sources, highest priority first
  always_comb begin
    force_vld = swr_now | run_rise | ovw_now;
    force_val = ALL_ONES;
    if (swr_now)       force_val = ALL_ONES;
    else if (run_rise) force_val = bus_wdata[B_RELOAD] ? load_q : ALL_ONES;
    else if (ovw_now)  force_val = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      load_q <= ALL_ONES;
      cmp_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= ctl_written(bus_wdata);
      if (swr_now) begin
        load_q <= ALL_ONES;
        cmp_q  <= '0;
        stat_q <= 1'b0;
      end else begin
        if (wr_load) load_q <= bus_wdata[CNT_W-1:0];
        if (wr_cmp)  cmp_q  <= bus_wdata[CNT_W-1:0];
        if (cmp_evt)       stat_q <= 1'b1;
        else if (stat_clr) stat_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_word)
      W_CTRL:  bus_rdata = ctl_q;
      W_STAT:  bus_rdata[0] = stat_q;
      W_LOAD:  bus_rdata[CNT_W-1:0] = load_q;
      W_CMP:   bus_rdata[CNT_W-1:0] = cmp_q;
      W_COUNT: bus_rdata[CNT_W-1:0] = cnt;
      default: bus_rdata = '0;
    endcase
  end

  assign ctl      = ctl_fields(ctl_q);
  assign load_val = load_q;
  assign cmp_val  = cmp_q;
  assign status   = stat_q;

  // R9: an event is visible in the flag on the next cycle
  a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && !swr_now) |=> status);

  // R10: the flag is sticky until cleared by a write of 1 or a soft reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !swr_now && !stat_clr) |=> status);

  // R4: soft reset leaves flag, load and compare at their reset values
  a_r4_soft: assert property (@(posedge clk) disable iff (!rst_n)
    swr_now |=> (!status && load_val == ALL_ONES && cmp_val == '0
                 && !ctl_q[B_SWRST]));

  // R2: upper control bits never become set
  a_r2_upper: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ctl_q[DATA_W-1:CTL_STORED] == '0));

endmodule

// File: rtl/cmp_downtimer.sv
module cmp_downtimer
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  ctl_t             ctl;
  logic [CNT_W-1:0] cnt, load_val, cmp_val, force_val;
  logic             cmp_evt, status, force_vld;

  cdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt       (cnt),
    .cmp_evt   (cmp_evt),
    .ctl       (ctl),
    .load_val  (load_val),
    .cmp_val   (cmp_val),
    .status    (status),
    .force_vld (force_vld),
    .force_val (force_val)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .run         (ctl.run),
    .reload_mode (ctl.reload),
    .load_val    (load_val),
    .force_vld   (force_vld),
    .force_val   (force_val),
    .cnt         (cnt)
  );

  cdt_compare #(.CNT_W(CNT_W)) u_compare (
    .run     (ctl.run),
    .cmp_ie  (ctl.cmp_ie),
    .tick    (tick),
    .cnt     (cnt),
    .cmp_val (cmp_val),
    .cmp_evt (cmp_evt)
  );

  assign irq = status & ctl.cmp_ie;

  // R8: a stopped timer produces no compare event
  a_r8_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.run && !status) |=> !status);

endmodule

// File: tb/cmp_downtimer_test.sv
module cmp_downtimer_test;

  localparam int unsigned W = 12;
  localparam logic [W-1:0] MAXV = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_word = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cmp_downtimer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // bench model of the register rules
  logic [31:0]  m_cr;
  logic         m_sr;
  logic [W-1:0] m_lr, m_cmp, m_cnt;

  function automatic logic [31:0] cr_after(input logic [31:0] d);
    logic [31:0] keep;
    keep = 32'h0000_0003 | (32'hF << 18);
    if (d[16]) return d & 32'h03FF_FFFF & keep;
    return d & 32'h03FF_FFFF;
  endfunction

  function automatic logic [W-1:0] next_cnt(input logic [W-1:0] c, input logic rl,
                                            input logic [W-1:0] lv);
    return (c == 0) ? (rl ? lv : MAXV) : W'(c - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cr <= '0; m_sr <= 1'b0; m_lr <= MAXV; m_cmp <= '0; m_cnt <= MAXV;
    end else begin
      logic we, ev, swr;
      we  = bus_sel && bus_wr;
      swr = we && bus_word == 3'd0 && bus_wdata[16];
      ev  = m_cr[0] && m_cr[2] && tick && (m_cnt == m_cmp);
      if (swr) m_cnt <= MAXV;
      else if (we && bus_word == 3'd0 && bus_wdata[0] && !m_cr[0] && bus_wdata[1])
        m_cnt <= bus_wdata[3] ? m_lr : MAXV;
      else if (we && bus_word == 3'd2 && m_cr[17]) m_cnt <= bus_wdata[W-1:0];
      else if (m_cr[0] && tick) m_cnt <= next_cnt(m_cnt, m_cr[3], m_lr);
      if (we && bus_word == 3'd0) m_cr <= cr_after(bus_wdata);
      if (swr) begin
        m_sr <= 1'b0; m_lr <= MAXV; m_cmp <= '0;
      end else begin
        if (we && bus_word == 3'd2) m_lr <= bus_wdata[W-1:0];
        if (we && bus_word == 3'd3) m_cmp <= bus_wdata[W-1:0];
        if (ev) m_sr <= 1'b1;
        else if (we && bus_word == 3'd1 && bus_wdata[0]) m_sr <= 1'b0;
      end
    end
  end

  function automatic logic [31:0] exp_word(input logic [2:0] w);
    case (w)
      3'd0: return m_cr;
      3'd1: return {31'b0, m_sr};
      3'd2: return {20'b0, m_lr};
      3'd3: return {20'b0, m_cmp};
      3'd4: return {20'b0, m_cnt};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    tick = 1'b0; bus_sel = 1'b1; bus_wr = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // read a word and compare against a literal expectation
  task automatic rd_lit(input logic [2:0] w, input logic [31:0] exp, input string tag);
    @(negedge clk);
    tick = 1'b0; bus_sel = 1'b0; bus_word = w;
    #1 check(tag, bus_rdata, exp);
  endtask

  // read a word and the interrupt and compare against the model
  task automatic rd_model(input logic [2:0] w, input string tag);
    @(negedge clk);
    bus_sel = 1'b0; bus_word = w;
    #1 check(tag, bus_rdata, exp_word(w));
    check("R12 irq", {31'b0, irq}, {31'b0, m_sr & m_cr[2]});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_lit(3'd0, 32'h0, "R1 ctrl");
    rd_lit(3'd1, 32'h0, "R1 status");
    rd_lit(3'd2, 32'hFFF, "R1 load");
    rd_lit(3'd3, 32'h0, "R1 compare");
    rd_lit(3'd4, 32'hFFF, "R1 count");
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 upper bits dropped
    wr(3'd0, 32'hFFFE_FFF0);
    rd_lit(3'd0, 32'h03FE_FFF0, "R2 ctrl store");

    // R11 overwrite armed, then not
    wr(3'd2, 32'd20);
    rd_lit(3'd4, 32'd20, "R11 overwrite");
    wr(3'd0, 32'h0);
    wr(3'd2, 32'd50);
    rd_lit(3'd4, 32'd20, "R11 no overwrite");

    // R13 count word ignores writes
    wr(3'd4, 32'd7);
    rd_lit(3'd4, 32'd20, "R13 count write ignored");
    rd_lit(3'd2, 32'd50, "R13 load untouched");

    // R5 restart from load
    wr(3'd0, 32'h0000_000B);
    rd_lit(3'd4, 32'd50, "R5 restart from load");

    // R7 stepping, reload and wrap
    ticks(10);
    rd_lit(3'd4, 32'd40, "R7 step");
    ticks(41);
    rd_lit(3'd4, 32'd50, "R7 reload at zero");
    wr(3'd0, 32'h0000_0003);
    ticks(51);
    rd_lit(3'd4, 32'hFFF, "R7 wrap to all-ones");

    // R8 freeze, no events while stopped
    wr(3'd0, 32'h0);
    ticks(20);
    rd_lit(3'd4, 32'hFFF, "R8 frozen");
    wr(3'd3, 32'hFFF);
    wr(3'd0, 32'h0000_0004);
    ticks(5);
    rd_lit(3'd1, 32'h0, "R8 no event");

    // R6 resume without restart
    wr(3'd0, 32'h0000_0001);
    ticks(5);
    rd_lit(3'd4, 32'hFFA, "R6 resume");

    // R9 compare at zero
    wr(3'd0, 32'h0);
    wr(3'd2, 32'd5);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'h0000_000F);
    ticks(5);
    rd_lit(3'd1, 32'h0, "R9 not yet");
    ticks(1);
    rd_lit(3'd1, 32'h1, "R9 zero compare fires");
    check("R12 irq high", {31'b0, irq}, 32'h1);

    // R10 clear rules, R9 repeat pass
    wr(3'd1, 32'h0);
    rd_lit(3'd1, 32'h1, "R10 write 0 keeps");
    wr(3'd1, 32'h1);
    rd_lit(3'd1, 32'h0, "R10 write 1 clears");
    ticks(6);
    rd_lit(3'd1, 32'h1, "R9 next pass fires");

    // R12 gating by compare-enable
    wr(3'd0, 32'h0000_000B);
    rd_lit(3'd1, 32'h1, "R12 flag kept");
    check("R12 irq gated", {31'b0, irq}, 32'h0);

    // R3 / R4 soft reset while running
    wr(3'd0, 32'h003F_000D);
    rd_lit(3'd0, 32'h003C_0001, "R3 kept bits");
    rd_lit(3'd1, 32'h0, "R4 status cleared");
    rd_lit(3'd2, 32'hFFF, "R4 load all-ones");
    rd_lit(3'd3, 32'h0, "R4 compare cleared");
    rd_lit(3'd4, 32'hFFF, "R4 count all-ones");
    ticks(3);
    rd_lit(3'd4, 32'hFFC, "R4 keeps running");

    // random phase against the model (R7 R9 R10 R11 R5 R6)
    for (int k = 0; k < 600; k++) begin
      int op;
      op = int'($urandom % 6);
      if (op < 3) begin
        logic [2:0] w;
        w = 3'($urandom % 5);
        d = $urandom;
        if (w == 3'd0 && ($urandom % 8) != 0) d[16] = 1'b0;
        if (w == 3'd2 || w == 3'd3) d = $urandom % 24;
        @(negedge clk);
        tick = $urandom % 2; bus_sel = 1'b1; bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
      end else begin
        int n;
        n = int'($urandom % 12);
        for (int i = 0; i < n; i++) begin
          @(negedge clk);
          tick = ($urandom % 4) != 0;
        end
      end
      rd_model(3'($urandom % 5), "R7/R9/R10 random");
    end

    finish_run();
  end

endmodule